// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

The block tells whether a voltage-controlled oscillator runs at the frequency its line rate calls for. It divides the oscillator clock by a ratio picked from the line rate, so that the divided clock nominally runs at 19.44 MHz. It then counts edges of that divided clock over a fixed window of reference-clock cycles and compares the count with the window length. Both clocks arrive as plain digital inputs. The edge count crosses into the reference domain as a Gray code through a two-flop synchroniser.

At the end of each window the deviation in counts sets a hysteretic lock flag. A small deviation sets the flag. A large deviation clears it. A deviation between the two limits leaves the flag as it was. With the default window of 2^14 reference cycles, a deviation below 4 counts is about 250 ppm and a deviation above 8 counts is about 500 ppm.

When no valid line signal is present, the raw flag can toggle from window to window. An optional de-chatter stage masks this toggling. It reports lock only after a run of consecutive locked windows, and it drops lock on the first window that reports unlock.

Top module: `lock_freq_detector`

## Requirements
- R1: While reset is asserted, and after reset until the first decision, `lock_raw_o` and `lock_o` are 0.
- R2: The first window after reset only records a baseline count. No decision is made before the end of the second window.
- R3: At the end of a window, an absolute deviation of the divided-clock count from 2^WIN_LOG2 that is less than ACQ_DEV sets `lock_raw_o` to 1.
- R4: At the end of a window, an absolute deviation greater than REL_DEV clears `lock_raw_o` to 0. This holds for a fast oscillator and for a slow one.
- R5: An absolute deviation from ACQ_DEV to REL_DEV inclusive leaves `lock_raw_o` unchanged, whether it was 1 or 0.
- R6: `rate_sel_i` selects the divide ratio. 2'b00 divides by 32, 2'b01 by 64, and 2'b10 and 2'b11 both divide by 128. An oscillator at the nominal frequency for the selected ratio locks. A ratio that does not match the oscillator frequency gives unlock.
- R7: The filtered lock rises only after FILT_WINS consecutive window decisions (default 4) that report lock.
- R8: The filtered lock falls after a single window decision that reports unlock.
- R9: With `dechatter_en_i` = 1, `lock_o` shows the filtered lock. With `dechatter_en_i` = 0, `lock_o` equals `lock_raw_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | 19.44 MHz reference clock |
| vco_clk_i | input | 1 | Oscillator clock to be checked |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_sel_i | input | 2 | Line-rate select that picks the divide ratio |
| dechatter_en_i | input | 1 | 1 routes the filtered lock to `lock_o` |
| lock_raw_o | output | 1 | Hysteretic lock flag, updated once per window |
| lock_o | output | 1 | Lock output, filtered or raw |

## Verification
The bench drives deviations of 0, ±6 and ±20 counts.
- The ±6 windows fall inside the hysteresis band. A design that compares against a single threshold would change state there.
- The ±20 windows fall outside it, on both sides. A design that tests only a fast oscillator would miss the slow case.
- The first window after reset is checked for no decision. A design that skips the baseline window would report lock one window early.

The bench changes the rate select along with the oscillator frequency. It also selects a ratio that does not match the oscillator, so a divider that ignores the select fails those checks.

For the filter, the bench builds runs of two locked windows broken by an unlock, which a filter that forgets to clear its run would pass through. It checks that the filtered output drops on the first unlock window, and it switches the filter bypass both ways.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;

  typedef enum logic [1:0] {
    RATE_LOW   = 2'b00,
    RATE_MID   = 2'b01,
    RATE_HIGH  = 2'b10,
    RATE_HIGH2 = 2'b11
  } rate_sel_e;

  // extra log2 divide on top of the base ratio
  function automatic int unsigned div_shift(input logic [1:0] sel);
    case (rate_sel_e'(sel))
      RATE_LOW: return 0;
      RATE_MID: return 1;
      default:  return 2;
    endcase
  endfunction

endpackage

// File: rtl/lock_vco_counter.sv
module lock_vco_counter #(
  parameter int unsigned DIV_BASE_LOG2 = 5,
  parameter int unsigned CNT_W         = 16
) (
  input  logic             vco_clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       rate_sel_i,
  output logic [CNT_W-1:0] gray_o
);
  localparam int unsigned PRE_W = DIV_BASE_LOG2 + 3;

  logic [1:0]       rate_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] div_m1;
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] gray_q;

  always_comb
    div_m1 = PRE_W'((32'd1 << (DIV_BASE_LOG2 + lock_det_pkg::div_shift(rate_q))) - 32'd1);

  always_ff @(posedge vco_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      pre_q  <= '0;
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      rate_q <= rate_sel_i;
      // >= so that a shrink of the ratio wraps at once
      if (pre_q >= div_m1) begin
        pre_q <= '0;
        bin_q <= bin_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
      gray_q <= bin_q ^ (bin_q >> 1);
    end
  end

  assign gray_o = gray_q;

  // crossing code may move by one bit at most per source clock (R6 count path)
  p_gray_single_step_r6: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/lock_gray_sync.sv
module lock_gray_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < int'(W); i++) bin_o[i] = ^(sync_q >> i);
  end

endmodule

// File: rtl/lock_window_eval.sv
module lock_window_eval #(
  parameter int unsigned WIN_LOG2 = 14,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned ACQ_DEV  = 4,
  parameter int unsigned REL_DEV  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             lock_raw_o,
  output logic             decide_o
);
  localparam int unsigned WIN = 1 << WIN_LOG2;
  localparam int unsigned DW  = CNT_W + 1;

  logic [WIN_LOG2-1:0] win_cnt_q;
  logic [CNT_W-1:0]    prev_q;
  logic                primed_q;
  logic                lock_q;
  logic                decide_q;
  logic                win_end;
  logic                decision;
  logic [CNT_W-1:0]    delta;
  logic signed [DW-1:0] dev;
  logic [DW-1:0]       dev_abs;
  logic                in_acq;
  logic                out_rel;

  always_comb begin
    win_end  = &win_cnt_q;
    decision = win_end & primed_q;
    delta    = cnt_i - prev_q;
    dev      = $signed({1'b0, delta}) - $signed(DW'(WIN));
    dev_abs  = dev[DW-1] ? DW'(-dev) : DW'(dev);
    in_acq   = dev_abs < DW'(ACQ_DEV);
    out_rel  = dev_abs > DW'(REL_DEV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      prev_q    <= '0;
      primed_q  <= 1'b0;
      lock_q    <= 1'b0;
      decide_q  <= 1'b0;
    end else begin
      win_cnt_q <= win_cnt_q + WIN_LOG2'(1);
      decide_q  <= decision;
      if (win_end) begin
        prev_q   <= cnt_i;
        primed_q <= 1'b1;
      end
      if (decision) begin
        if (in_acq)       lock_q <= 1'b1;
        else if (out_rel) lock_q <= 1'b0;
      end
    end
  end

  assign lock_raw_o = lock_q;
  assign decide_o   = decide_q;

  p_no_lock_unprimed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |-> !lock_q);
  p_acquire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision && in_acq |=> lock_q);
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision && out_rel |=> !lock_q);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(decision && (in_acq || out_rel)) |=> $stable(lock_q));

endmodule

// File: rtl/lock_dechatter.sv
module lock_dechatter #(
  parameter int unsigned FILT_WINS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decide_i,
  input  logic lock_i,
  output logic filt_o
);
  localparam int unsigned RW = $clog2(FILT_WINS + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (decide_i) begin
      if (!lock_i)                       run_q <= '0;
      else if (run_q != RW'(FILT_WINS))  run_q <= run_q + RW'(1);
    end
  end

  assign filt_o = (run_q == RW'(FILT_WINS));

  p_drop_on_unlock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide_i && !lock_i |=> !filt_o);
  p_rise_on_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_o) |-> $past(decide_i) && $past(lock_i));

endmodule

// File: rtl/lock_freq_detector.sv
module lock_freq_detector #(
  parameter int unsigned WIN_LOG2      = 14,
  parameter int unsigned ACQ_DEV       = 4,
  parameter int unsigned REL_DEV       = 8,
  parameter int unsigned DIV_BASE_LOG2 = 5,
  parameter int unsigned FILT_WINS     = 4
) (
  input  logic       ref_clk_i,
  input  logic       vco_clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_sel_i,
  input  logic       dechatter_en_i,
  output logic       lock_raw_o,
  output logic       lock_o
);
  // two spare bits so one window's delta never aliases
  localparam int unsigned CNT_W = WIN_LOG2 + 2;

  logic [CNT_W-1:0] gray_vco;
  logic [CNT_W-1:0] cnt_ref;
  logic             lock_raw;
  logic             decide;
  logic             lock_filt;

  lock_vco_counter #(.DIV_BASE_LOG2(DIV_BASE_LOG2), .CNT_W(CNT_W)) u_vco_cnt (
    .vco_clk_i (vco_clk_i),
    .rst_ni    (rst_ni),
    .rate_sel_i(rate_sel_i),
    .gray_o    (gray_vco)
  );

  lock_gray_sync #(.W(CNT_W)) u_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .gray_i(gray_vco),
    .bin_o (cnt_ref)
  );

  lock_window_eval #(
    .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .ACQ_DEV(ACQ_DEV), .REL_DEV(REL_DEV)
  ) u_eval (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_ref),
    .lock_raw_o(lock_raw),
    .decide_o  (decide)
  );

  lock_dechatter #(.FILT_WINS(FILT_WINS)) u_filt (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .decide_i(decide),
    .lock_i  (lock_raw),
    .filt_o  (lock_filt)
  );

  assign lock_raw_o = lock_raw;
  assign lock_o     = dechatter_en_i ? lock_filt : lock_raw;

endmodule

// File: tb/lock_freq_detector_tb_top.sv
module lock_freq_detector_tb_top;
  localparam int REF_PERIOD = 51440;
  localparam int WIN_LOG2   = 8;
  localparam int WIN        = 1 << WIN_LOG2;
  localparam int ACQ        = 4;
  localparam int REL        = 8;
  localparam int FILT       = 4;
  localparam int LAST_WIN   = 23;

  logic       ref_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       dechatter_en = 1'b1;
  logic       lock_raw;
  logic       lock;

  real vco_half = REF_PERIOD / 64.0;
  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    bit    raw;
    bit    filt;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  bit m_raw = 1'b0;
  int m_run = 0;
  bit m_primed = 1'b0;

  always #(REF_PERIOD / 2) ref_clk = ~ref_clk;
  always #(vco_half) vco_clk = ~vco_clk;
  always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

  lock_freq_detector #(
    .WIN_LOG2(WIN_LOG2), .ACQ_DEV(ACQ), .REL_DEV(REL), .DIV_BASE_LOG2(5), .FILT_WINS(FILT)
  ) dut_i (
    .ref_clk_i     (ref_clk),
    .vco_clk_i     (vco_clk),
    .rst_ni        (rst_n),
    .rate_sel_i    (rate_sel),
    .dechatter_en_i(dechatter_en),
    .lock_raw_o    (lock_raw),
    .lock_o        (lock)
  );

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // monitor: one expectation per window, sampled mid-window
  always @(negedge ref_clk) begin
    exp_t e;
    if (rst_n && !done && (cyc % WIN == WIN / 2) && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check(e.tag, "lock_raw_o", lock_raw, e.raw);
      check(e.tag, "lock_o", lock, dechatter_en ? e.filt : e.raw);
    end
  end

  // driver: sets window stimulus and pushes the modelled result
  task automatic run_win(input int k, input int dev, input logic [1:0] sel,
                         input int mult, input bit en, input string tag);
    int div;
    int eff;
    int mag;
    exp_t e;
    while (cyc != k * WIN) @(negedge ref_clk);
    rate_sel     = sel;
    dechatter_en = en;
    vco_half     = (1.0 * REF_PERIOD * WIN) / (2.0 * mult * (WIN + dev));
    div = (sel == 2'b00) ? 32 : (sel == 2'b01) ? 64 : 128;
    eff = ((WIN + dev) * mult) / div - WIN;
    mag = (eff < 0) ? -eff : eff;
    if (m_primed) begin
      if (mag < ACQ)      m_raw = 1'b1;
      else if (mag > REL) m_raw = 1'b0;
      m_run = m_raw ? ((m_run < FILT) ? m_run + 1 : m_run) : 0;
    end
    m_primed = 1'b1;
    e.raw  = m_raw;
    e.filt = (m_run == FILT);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    exp_t e0;
    e0.raw = 1'b0; e0.filt = 1'b0; e0.tag = "R1 after reset";
    exp_q.push_back(e0);
    repeat (5) @(negedge ref_clk);
    check("R1 in reset", "lock_raw_o", lock_raw, 1'b0);
    check("R1 in reset", "lock_o", lock, 1'b0);
    rst_n = 1'b1;

    run_win(0,    0, 2'b00,  32, 1'b1, "R2 baseline");
    run_win(1,    0, 2'b00,  32, 1'b1, "R3 acquire");
    run_win(2,    0, 2'b00,  32, 1'b1, "R7 run2");
    run_win(3,    0, 2'b00,  32, 1'b1, "R7 run3");
    run_win(4,    0, 2'b00,  32, 1'b1, "R7 run4");
    run_win(5,    6, 2'b00,  32, 1'b1, "R5 hold high");
    run_win(6,   20, 2'b00,  32, 1'b1, "R4 R8 release fast");
    run_win(7,    6, 2'b00,  32, 1'b1, "R5 hold low");
    run_win(8,    0, 2'b00,  32, 1'b1, "R3 reacquire");
    run_win(9,   20, 2'b00,  32, 1'b1, "R8 chatter");
    run_win(10,   0, 2'b00,  32, 1'b1, "R7 run1");
    run_win(11,   0, 2'b00,  32, 1'b1, "R7 run2");
    run_win(12, -20, 2'b00,  32, 1'b1, "R4 release slow");
    run_win(13,  -6, 2'b00,  32, 1'b1, "R5 hold low slow");
    run_win(14,   0, 2'b00,  32, 1'b0, "R9 bypass");
    run_win(15,  -6, 2'b00,  32, 1'b0, "R5 R9 hold high slow");
    run_win(16,   0, 2'b01,  64, 1'b0, "R6 ratio64");
    run_win(17,   0, 2'b10, 128, 1'b0, "R6 ratio128");
    run_win(18,  20, 2'b10, 128, 1'b0, "R4 ratio128");
    run_win(19,   0, 2'b11, 128, 1'b0, "R6 sel3");
    run_win(20,   0, 2'b01, 128, 1'b0, "R6 mismatch");
    run_win(21, -20, 2'b00,  32, 1'b1, "R6 recover");
    run_win(22,   0, 2'b00,  32, 1'b1, "R9 filtered");
    run_win(LAST_WIN, 0, 2'b00, 32, 1'b1, "R9 filtered run2");

    while (cyc < (LAST_WIN + 1) * WIN + WIN / 2 + 2) @(negedge ref_clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(1.0 * REF_PERIOD * 40000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule